// File: doc/BRIEF.md
# Paged Byte-Wide Boot Loader

This block fills the internal 24-bit program RAM from an external memory that is only eight bits wide. It builds one RAM word from three consecutive byte reads, generates the boot memory address together with an active-low boot select and read strobe, and stretches each read by a programmable number of wait states. The external boot space holds eight pages. One page is loaded per boot sequence, and the page number goes out on spare pins so that it supplies the high bits of the boot memory address.

A sequence starts by itself after reset when the memory-map select input is low. Software can also start one with a force pulse, using the page field. Between byte reads the loader checks the external bus request. If a request is present it parks its strobes and grants the bus, and it resumes once the request is withdrawn. When the final word has been written, a one-cycle done pulse tells the core to begin execution at program address 0x0000.

Top module: `byte_boot_loader`

## Requirements
- R1: After reset with memory-map select high, the boot select, read strobe and bus grant stay inactive (select and strobe high, grant low), the active flag stays low, and no RAM write or done pulse occurs.
- R2: In the first cycle after reset, if memory-map select is low, a boot of page 0 starts. The page input is ignored for this boot.
- R3: RAM word n is written at RAM address n, in ascending order. Its bits 23:16, 15:8 and 7:0 hold the bytes read from page byte offsets 3n, 3n+1 and 3n+2 respectively.
- R4: During a read, address bits 10:0 carry the byte offset within the page, address bits 12:11 are 0, address bit 13 carries page bit 0, the two high-data-pin outputs carry page bits 2:1 with their enable high, and the byte is taken from the 8-bit boot data input (data pins 15:8).
- R5: Boot select and read strobe fall and rise together. Each read holds them low for exactly W+1 cycles, where W is the wait setting, and they stay high for at least one cycle between reads.
- R6: The wait setting resets to 3. A write changes it to any value from 0 to 7, and the new value applies to reads that start afterwards.
- R7: A force pulse while idle starts a boot of the page on the page input. The page is captured at the start. A force pulse during a boot is ignored: it neither changes the page being loaded nor queues a second boot.
- R8: A bus request during a boot is granted only between byte reads. No read is active while the grant is high. After the request is withdrawn, the boot continues with no lost or repeated byte.
- R9: If a bus request is pending when an automatic boot starts, the grant is given before the first byte read.
- R10: Done is high for exactly one cycle, together with the RAM write of the last word. The loader is then idle.
- R11: A boot writes BOOT_WORDS words, with RAM addresses from 0 to BOOT_WORDS-1. The default is the full 512-word RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmap_i | input | 1 | Memory-map select; low enables the boot after reset |
| page_i | input | 3 | Page number for a forced boot |
| force_i | input | 1 | Forced boot request pulse |
| wait_wr_i | input | 1 | Write strobe for the wait setting |
| wait_val_i | input | 3 | New wait setting (0 to 7) |
| bus_req_i | input | 1 | External bus request |
| bus_grant_o | output | 1 | External bus grant |
| boot_sel_n_o | output | 1 | Boot memory select, active low |
| boot_rd_n_o | output | 1 | Read strobe, active low |
| ext_addr_o | output | 14 | External address pins |
| ext_byte_i | input | 8 | Boot data from data pins 15:8 |
| ext_dhi_o | output | 2 | Page bits 2:1 for data pins 23:22 |
| ext_dhi_oe_o | output | 1 | Drive enable for data pins 23:22 |
| ram_we_o | output | 1 | Program RAM write enable |
| ram_addr_o | output | 9 | Program RAM word address |
| ram_data_o | output | 24 | Program RAM write data |
| boot_active_o | output | 1 | A boot sequence is in progress |
| done_o | output | 1 | One-cycle pulse on the last word write |

## Verification
A byte-lane counter or offset counter that is off by one does not stay hidden. The first RAM write, about three reads after the start, already carries a misordered or shifted word. A wrong page register or a wrong pin mapping appears on the address and high-data pins in the first read cycle. A wrong wait count shows up as a wrong read-strobe width on the first byte. An arbiter that grants during a read, or loses its place while granted, is caught either in the grant cycle itself or at the first word written after the grant ends. A wrong end count shows up at the done pulse, where the words written are compared against the expected list.

// File: rtl/byte_boot_pkg.sv
package byte_boot_pkg;

   typedef enum logic [1:0] {
      BST_IDLE = 2'd0,
      BST_GAP  = 2'd1,
      BST_READ = 2'd2,
      BST_HOLD = 2'd3
   } bst_e;

endpackage

// File: rtl/bbl_wait_timer.sv
// Wait-state setting register and per-read countdown.
module bbl_wait_timer #(
   parameter int unsigned WAIT_W   = 3,
   parameter int unsigned WAIT_RST = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [WAIT_W-1:0] cfg_val,
   input  logic              load,
   input  logic              dec,
   output logic              expired
);

   logic [WAIT_W-1:0] cfg_q;
   logic [WAIT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= WAIT_W'(WAIT_RST);
      end else if (cfg_wr) begin
         cfg_q <= cfg_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= cfg_q;
      end else if (dec && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/bbl_addr_map.sv
// Page/offset register and mapping onto address and high data pins.
module bbl_addr_map #(
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned OFF_W  = 11,
   parameter int unsigned PAGE_W = 3,
   parameter int unsigned DHI_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PAGE_W-1:0] start_page,
   input  logic              step,
   input  logic              drive,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DHI_W-1:0]  dhi_o,
   output logic              dhi_oe_o
);

   localparam int unsigned APG_W  = PAGE_W - DHI_W;
   localparam int unsigned APG_LO = ADDR_W - APG_W;

   logic [PAGE_W-1:0] page_q;
   logic [OFF_W-1:0]  off_q;
   logic [ADDR_W-1:0] addr_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         off_q  <= '0;
      end else if (start) begin
         page_q <= start_page;
         off_q  <= '0;
      end else if (step) begin
         off_q  <= off_q + 1'b1;
      end
   end

   for (genvar b = 0; b < int'(ADDR_W); b++) begin : g_abit
      if (b < int'(OFF_W)) begin : g_off
         assign addr_full[b] = off_q[b];
      end else if (b >= int'(APG_LO)) begin : g_page
         assign addr_full[b] = page_q[b - int'(APG_LO)];
      end else begin : g_zero
         assign addr_full[b] = 1'b0;
      end
   end

   assign addr_o   = drive ? addr_full : '0;
   assign dhi_o    = drive ? page_q[PAGE_W-1 -: DHI_W] : '0;
   assign dhi_oe_o = drive;

endmodule

// File: rtl/bbl_word_packer.sv
// Packs bytes most significant first into words and issues RAM writes.
module bbl_word_packer #(
   parameter int unsigned WORD_W = 24,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned RAM_AW = 9,
   parameter int unsigned NWORDS = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              capture,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              word_end,
   output logic              last_word,
   output logic              ram_we_o,
   output logic [RAM_AW-1:0] ram_addr_o,
   output logic [WORD_W-1:0] ram_data_o
);

   localparam int unsigned LANES  = WORD_W / BYTE_W;
   localparam int unsigned LANE_W = $clog2(LANES);
   localparam int unsigned ACC_W  = WORD_W - BYTE_W;

   logic [LANE_W-1:0] lane_q;
   logic [ACC_W-1:0]  acc_q;
   logic [RAM_AW-1:0] word_q;

   assign word_end  = capture && (lane_q == LANE_W'(LANES - 1));
   assign last_word = (word_q == RAM_AW'(NWORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_q <= '0;
         acc_q  <= '0;
         word_q <= '0;
      end else if (start) begin
         lane_q <= '0;
         word_q <= '0;
      end else if (capture) begin
         acc_q <= {acc_q[ACC_W-BYTE_W-1:0], byte_in};
         if (word_end) begin
            lane_q <= '0;
            word_q <= word_q + 1'b1;
         end else begin
            lane_q <= lane_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ram_we_o   <= 1'b0;
         ram_addr_o <= '0;
         ram_data_o <= '0;
      end else begin
         ram_we_o <= word_end;
         if (word_end) begin
            ram_addr_o <= word_q;
            ram_data_o <= {acc_q, byte_in};
         end
      end
   end

endmodule

// File: rtl/byte_boot_loader.sv
module byte_boot_loader
   import byte_boot_pkg::*;
#(
   parameter int unsigned ADDR_W     = 14,
   parameter int unsigned WORD_W     = 24,
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned PAGE_BYTES = 2048,
   parameter int unsigned NUM_PAGES  = 8,
   parameter int unsigned RAM_WORDS  = 512,
   parameter int unsigned BOOT_WORDS = 512,
   parameter int unsigned WAIT_W     = 3,
   parameter int unsigned WAIT_RST   = 3,
   parameter int unsigned DHI_W      = 2,
   localparam int unsigned PAGE_W    = $clog2(NUM_PAGES),
   localparam int unsigned RAM_AW    = $clog2(RAM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mmap_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic              force_i,
   input  logic              wait_wr_i,
   input  logic [WAIT_W-1:0] wait_val_i,
   input  logic              bus_req_i,
   output logic              bus_grant_o,
   output logic              boot_sel_n_o,
   output logic              boot_rd_n_o,
   output logic [ADDR_W-1:0] ext_addr_o,
   input  logic [BYTE_W-1:0] ext_byte_i,
   output logic [DHI_W-1:0]  ext_dhi_o,
   output logic              ext_dhi_oe_o,
   output logic              ram_we_o,
   output logic [RAM_AW-1:0] ram_addr_o,
   output logic [WORD_W-1:0] ram_data_o,
   output logic              boot_active_o,
   output logic              done_o
);

   localparam int unsigned OFF_W = $clog2(PAGE_BYTES);
   localparam int unsigned LANES = WORD_W / BYTE_W;

   // elaboration-time parameter checks
   if ((1 << PAGE_W) != NUM_PAGES) begin : g_chk_pages
      $error("NUM_PAGES must be a power of two");
   end
   if ((1 << OFF_W) != PAGE_BYTES) begin : g_chk_pbytes
      $error("PAGE_BYTES must be a power of two");
   end
   if ((WORD_W % BYTE_W) != 0 || LANES < 2) begin : g_chk_lanes
      $error("WORD_W must be at least two whole bytes");
   end
   if (BOOT_WORDS * LANES > PAGE_BYTES) begin : g_chk_fit
      $error("boot image does not fit in one page");
   end
   if (BOOT_WORDS > RAM_WORDS || BOOT_WORDS == 0) begin : g_chk_ram
      $error("BOOT_WORDS out of range");
   end
   if (DHI_W == 0 || DHI_W > PAGE_W) begin : g_chk_dhi
      $error("DHI_W must be between 1 and PAGE_W");
   end
   if (OFF_W + PAGE_W - DHI_W > ADDR_W) begin : g_chk_addr
      $error("address pins too narrow for offset and page bits");
   end
   if (WAIT_RST >= (1 << WAIT_W)) begin : g_chk_wait
      $error("WAIT_RST does not fit in WAIT_W");
   end

   bst_e              st_q, st_d;
   logic              auto_q;
   logic              done_q;
   logic              expired, capture, word_end, last_word;
   logic              start_auto, start_force, start;
   logic [PAGE_W-1:0] start_page;
   logic              load;

   assign start_auto  = (st_q == BST_IDLE) && auto_q && !mmap_i;
   assign start_force = (st_q == BST_IDLE) && !start_auto && force_i;
   assign start       = start_auto || start_force;
   assign start_page  = start_auto ? '0 : page_i;
   assign capture     = (st_q == BST_READ) && expired;
   assign load        = (st_q == BST_GAP) && !bus_req_i;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         BST_IDLE: if (start) st_d = BST_GAP;
         BST_GAP:  st_d = bus_req_i ? BST_HOLD : BST_READ;
         BST_HOLD: if (!bus_req_i) st_d = BST_GAP;
         BST_READ: if (capture) st_d = (word_end && last_word) ? BST_IDLE : BST_GAP;
         default:  st_d = BST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= BST_IDLE;
         auto_q <= 1'b1;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= capture && word_end && last_word;
         if (st_q == BST_IDLE) auto_q <= 1'b0;
      end
   end

   bbl_wait_timer #(
      .WAIT_W  (WAIT_W),
      .WAIT_RST(WAIT_RST)
   ) wait_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_wr (wait_wr_i),
      .cfg_val(wait_val_i),
      .load   (load),
      .dec    (st_q == BST_READ),
      .expired(expired)
   );

   bbl_addr_map #(
      .ADDR_W(ADDR_W),
      .OFF_W (OFF_W),
      .PAGE_W(PAGE_W),
      .DHI_W (DHI_W)
   ) amap_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_page(start_page),
      .step      (capture),
      .drive     (st_q == BST_READ),
      .addr_o    (ext_addr_o),
      .dhi_o     (ext_dhi_o),
      .dhi_oe_o  (ext_dhi_oe_o)
   );

   bbl_word_packer #(
      .WORD_W(WORD_W),
      .BYTE_W(BYTE_W),
      .RAM_AW(RAM_AW),
      .NWORDS(BOOT_WORDS)
   ) pack_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .capture   (capture),
      .byte_in   (ext_byte_i),
      .word_end  (word_end),
      .last_word (last_word),
      .ram_we_o  (ram_we_o),
      .ram_addr_o(ram_addr_o),
      .ram_data_o(ram_data_o)
   );

   assign boot_sel_n_o  = (st_q != BST_READ);
   assign boot_rd_n_o   = (st_q != BST_READ);
   assign bus_grant_o   = (st_q == BST_HOLD);
   assign boot_active_o = (st_q != BST_IDLE);
   assign done_o        = done_q;

endmodule

// File: rtl/byte_boot_loader_chk.sv
module byte_boot_loader_chk #(
   parameter int unsigned ADDR_W     = 14,
   parameter int unsigned RAM_AW     = 9,
   parameter int unsigned WAIT_W     = 3,
   parameter int unsigned BOOT_WORDS = 512
) (
   input logic              clk,
   input logic              rst_n,
   input logic              boot_sel_n_o,
   input logic              boot_rd_n_o,
   input logic              bus_grant_o,
   input logic              bus_req_i,
   input logic              ram_we_o,
   input logic [RAM_AW-1:0] ram_addr_o,
   input logic              done_o,
   input logic              boot_active_o,
   input logic [ADDR_W-1:0] ext_addr_o
);

   logic [WAIT_W+1:0] rd_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_len_q <= '0;
      else if (!boot_sel_n_o) rd_len_q <= rd_len_q + 1'b1;
      else rd_len_q <= '0;
   end

   AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_active_o |-> (boot_sel_n_o && boot_rd_n_o && !bus_grant_o)); // R1

   AST_SEL_WITH_RD: assert property (@(posedge clk) disable iff (!rst_n)
      boot_sel_n_o == boot_rd_n_o); // R5

   AST_READ_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_sel_n_o |-> (rd_len_q < (WAIT_W+2)'(1 << WAIT_W))); // R5

   AST_ADDR_STABLE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!boot_sel_n_o && $past(!boot_sel_n_o)) |-> $stable(ext_addr_o)); // R4

   AST_NO_READ_WHILE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_grant_o |-> boot_sel_n_o); // R8

   AST_GRANT_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_grant_o) |-> $past(bus_req_i)); // R8

   AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ram_we_o && ram_addr_o == RAM_AW'(BOOT_WORDS - 1))); // R10

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R10

   AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we_o |-> (ram_addr_o <= RAM_AW'(BOOT_WORDS - 1))); // R11

endmodule

bind byte_boot_loader byte_boot_loader_chk #(
   .ADDR_W    (ADDR_W),
   .RAM_AW    (RAM_AW),
   .WAIT_W    (WAIT_W),
   .BOOT_WORDS(BOOT_WORDS)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .boot_sel_n_o (boot_sel_n_o),
   .boot_rd_n_o  (boot_rd_n_o),
   .bus_grant_o  (bus_grant_o),
   .bus_req_i    (bus_req_i),
   .ram_we_o     (ram_we_o),
   .ram_addr_o   (ram_addr_o),
   .done_o       (done_o),
   .boot_active_o(boot_active_o),
   .ext_addr_o   (ext_addr_o)
);

// File: tb/byte_boot_loader_tb_top.sv
module byte_boot_loader_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NW         = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mmap = 1'b1;
   logic [2:0]  page = 3'd0;
   logic        force_b = 1'b0;
   logic        wait_wr = 1'b0;
   logic [2:0]  wait_val = 3'd0;
   logic        bus_req = 1'b0;
   logic        grant, sel_n, rd_n, dhi_oe, we, active, done;
   logic [13:0] addr;
   logic [7:0]  ext_byte;
   logic [1:0]  dhi;
   logic [8:0]  ram_addr;
   logic [23:0] ram_data;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic [8:0]  exp_addr_q[$];
   logic [23:0] exp_data_q[$];
   int   exp_wait = 3;
   int   cur_page = 0;
   int   exp_off  = 0;
   int   done_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   byte_boot_loader #(.BOOT_WORDS(NW)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .mmap_i       (mmap),
      .page_i       (page),
      .force_i      (force_b),
      .wait_wr_i    (wait_wr),
      .wait_val_i   (wait_val),
      .bus_req_i    (bus_req),
      .bus_grant_o  (grant),
      .boot_sel_n_o (sel_n),
      .boot_rd_n_o  (rd_n),
      .ext_addr_o   (addr),
      .ext_byte_i   (ext_byte),
      .ext_dhi_o    (dhi),
      .ext_dhi_oe_o (dhi_oe),
      .ram_we_o     (we),
      .ram_addr_o   (ram_addr),
      .ram_data_o   (ram_data),
      .boot_active_o(active),
      .done_o       (done)
   );

   function automatic logic [7:0] mem_byte(input int a);
      int v;
      v = (a * 157) ^ (a >> 5);
      return 8'(v) + 8'h11;
   endfunction

   // boot memory model: EPROM address = {data23:22, addr13, addr10:0}
   always_comb begin
      if (!sel_n && !rd_n)
         ext_byte = mem_byte(int'({dhi, addr[13], addr[10:0]}));
      else
         ext_byte = 8'hA5;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // driver side of the scoreboard
   task automatic push_boot(input int p);
      for (int w = 0; w < NW; w++) begin
         int b;
         b = p * 2048 + 3 * w;
         exp_addr_q.push_back(9'(w));
         exp_data_q.push_back({mem_byte(b), mem_byte(b + 1), mem_byte(b + 2)});
      end
      cur_page = p;
      exp_off  = 0;
   endtask

   task automatic pulse_force(input int p);
      @(negedge clk);
      force_b = 1'b1;
      page    = 3'(p);
      @(negedge clk);
      force_b = 1'b0;
   endtask

   task automatic set_wait(input int v);
      @(negedge clk);
      wait_wr  = 1'b1;
      wait_val = 3'(v);
      @(negedge clk);
      wait_wr  = 1'b0;
      exp_wait = v;
   endtask

   task automatic wait_done(input string tag);
      int start_cnt;
      int n;
      start_cnt = done_cnt;
      n = 0;
      while (done_cnt == start_cnt && n < 5000) begin
         @(negedge clk);
         n++;
      end
      check(done_cnt > start_cnt, tag, done_cnt, start_cnt + 1);
   endtask

   // monitor side of the scoreboard
   bit prev_sel_n = 1'b1;
   bit prev_done  = 1'b0;
   int rlen = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (we) begin
            if (exp_addr_q.size() == 0) begin
               check(1'b0, "R3 unexpected RAM write", int'(ram_addr), -1);
            end else begin
               logic [8:0]  ea;
               logic [23:0] ed;
               ea = exp_addr_q.pop_front();
               ed = exp_data_q.pop_front();
               check(ram_addr == ea, "R3 RAM address", int'(ram_addr), int'(ea));
               check(ram_data == ed, "R3 RAM word", int'(ram_data), int'(ed));
            end
         end
         if (done) begin
            check(we && ram_addr == 9'(NW - 1), "R10 done with last write", int'(ram_addr), NW - 1);
            check(exp_addr_q.size() == 0, "R11 words written at done", exp_addr_q.size(), 0);
            check(!prev_done, "R10 done single cycle", 1, 0);
            done_cnt++;
         end
         if (grant) check(sel_n && rd_n, "R8 no read while granted", int'(sel_n), 1);
         if (sel_n != rd_n) check(1'b0, "R5 select and strobe together", int'(sel_n), int'(rd_n));
         if (!sel_n && prev_sel_n) begin
            check(addr[12:11] == 2'b00 && dhi_oe && int'({dhi, addr[13]}) == cur_page,
                  "R4 page pins", int'({dhi_oe, dhi, addr[13:11]}), cur_page);
            check(int'(addr[10:0]) == exp_off, "R4 byte offset", int'(addr[10:0]), exp_off);
            exp_off++;
            rlen = 1;
         end else if (!sel_n) begin
            rlen++;
         end else if (!prev_sel_n) begin
            check(rlen == exp_wait + 1, "R5 R6 read window length", rlen, exp_wait + 1);
         end
         prev_sel_n = sel_n;
         prev_done  = done;
      end else begin
         prev_sel_n = 1'b1;
         prev_done  = 1'b0;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      // R1: reset with memory-map select high, nothing happens
      mmap  = 1'b1;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check(sel_n && rd_n && !grant && !active && !done && !we, "R1 reset state quiet",
            int'({sel_n, rd_n, grant, active, done, we}), 6'b110000);
      check(dhi_oe == 1'b0, "R1 high data pins released", int'(dhi_oe), 0);

      // R7 R3 R4 R5 R6: forced boot of page 5 with default wait 3
      push_boot(5);
      pulse_force(5);
      wait_done("R7 forced boot page 5 completes");
      @(negedge clk);
      check(!active, "R10 idle after done", int'(active), 0);

      // R6: zero wait states, page 2
      set_wait(0);
      push_boot(2);
      pulse_force(2);
      wait_done("R6 boot with zero wait completes");

      // R7 R8: seven wait states, page 7, ignored force and a bus request mid-boot
      set_wait(7);
      push_boot(7);
      pulse_force(7);
      repeat (60) @(negedge clk);
      pulse_force(1);
      repeat (40) @(negedge clk);
      bus_req = 1'b1;
      begin
         int n;
         n = 0;
         while (!grant && n < 20) begin
            @(negedge clk);
            n++;
         end
         check(grant == 1'b1 && n <= 10, "R8 grant between bytes", n, 10);
      end
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         check(grant && sel_n, "R8 grant held while requested", int'({grant, sel_n}), 2'b11);
      end
      bus_req = 1'b0;
      wait_done("R8 boot resumes after grant");
      repeat (20) @(negedge clk);
      check(!active && sel_n, "R7 force during boot not queued", int'(active), 0);

      // R9 R2 R6: reset with select low and a pending bus request
      mmap    = 1'b0;
      bus_req = 1'b1;
      page    = 3'd6;
      @(negedge clk);
      rst_n = 1'b0;
      exp_wait = 3;
      repeat (3) @(negedge clk);
      push_boot(0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check(grant && sel_n && active, "R9 pending request granted first",
            int'({grant, sel_n, active}), 3'b111);
      bus_req = 1'b0;
      wait_done("R2 automatic boot of page 0");
      repeat (10) @(negedge clk);
      check(!active, "R2 single automatic boot", int'(active), 0);

      finish_run();
   end

endmodule